// File: doc/BRIEF.md
# Bit-Band Alias Address Translator

This block sits between a 32-bit bus master and a byte-addressable memory with one cycle of read latency. It watches every request address. When an address falls inside the bit-band alias window, the block turns the word access into an operation on a single bit of one byte in the backing region. An alias read returns that bit, zero-extended into a word. An alias write changes only that bit, using an atomic read-modify-write. Every other address goes straight through to memory, unchanged.

The master presents a request and holds it until the block raises ready in the same cycle. Read data returns with a valid strobe one cycle after acceptance. An alias write takes two cycles. In the first cycle the block reads the backing word while holding the master off. In the second cycle the block writes back one byte lane and accepts the request.

Top module: `bitband_bridge`

## Requirements
- R1: After reset, with no request present, `m_ready` is 1, `m_rvalid` is 0 and `mem_req` is 0.
- R2: An address is in the alias window when its bits [31:25] equal those of 0x2200_0000, that is 0x2200_0000 to 0x23FF_FFFF. Addresses such as 0x21FF_FFFC and 0x2400_0000 are outside it.
- R3: For an alias address A, the target byte is at 0x2000_0000 + A[24:5] and the target bit is A[4:2]. The memory port receives the byte address with bits [1:0] cleared, and only byte-enable bit (byte address [1:0]) set. For example, 0x2200_6008 maps to bit 2 of the byte at 0x2000_0300.
- R4: An alias write completes in two cycles with `m_ready` low then high. The first cycle is a memory read. The second cycle is a memory write with exactly one byte enable. After it, only the targeted bit of the backing word has changed.
- R5: On an alias write, only bit 0 of `m_wdata` gives the new value of the bit. Bits [31:1] have no effect.
- R6: An alias read is accepted in one cycle. One cycle later it returns 0x0000_0001 if the target bit is set and 0x0000_0000 if it is clear.
- R7: A request outside the window drives `mem_addr`, `mem_we`, `mem_be` and `mem_wdata` equal to the master's values in the same cycle and is accepted in that cycle. For a read, `m_rdata` equals the memory word one cycle after acceptance.
- R8: Between the internal read and the write-back of an alias write, `m_ready` stays low, so no other request is accepted.
- R9: `mem_req` is low whenever the master has no request and no write-back is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| m_req | input | 1 | Master request, held until accepted |
| m_we | input | 1 | Master write (1) or read (0) |
| m_addr | input | 32 | Master byte address |
| m_wdata | input | 32 | Master write data |
| m_be | input | 4 | Master byte enables |
| m_ready | output | 1 | Request accepted this cycle when high with `m_req` |
| m_rvalid | output | 1 | Read data valid, one cycle after read acceptance |
| m_rdata | output | 32 | Read data to master |
| mem_req | output | 1 | Memory access strobe |
| mem_we | output | 1 | Memory write |
| mem_addr | output | 32 | Memory byte address |
| mem_be | output | 4 | Memory byte enables |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, one cycle after a read strobe |

## Verification
Three kinds of result come due at different times. Memory-port values for a pass-through access, or for the read phase of an alias access, are due in the same cycle the request is driven. The write-back of an alias write is due in the next cycle, when ready rises. Read data and its valid strobe are due one cycle after the accepting edge. The bench drives each request on a falling edge and samples the memory port and ready shortly after that edge, in every cycle until ready is seen. It collects the return data at the falling edge that follows the accepting rising edge. The bench also counts the cycles each access spends waiting for ready and compares the count with one or two, as the requirements set out.

// File: rtl/bb_pkg.sv
package bb_pkg;

  typedef enum logic {
    BB_IDLE = 1'b0,
    BB_WB   = 1'b1
  } bb_state_e;

  // Byte address in the backing region for a given alias byte offset.
  function automatic logic [31:0] bb_region_byte(input logic [31:0] base,
                                                 input logic [31:0] offset);
    return base + offset;
  endfunction

  // Copy of a word with one bit (lane*8 + bitn) forced to v.
  function automatic logic [31:0] bb_set_bit(input logic [31:0] w,
                                             input logic [1:0]  lane,
                                             input logic [2:0]  bitn,
                                             input logic        v);
    logic [31:0] r;
    r = w;
    r[{lane, bitn}] = v;
    return r;
  endfunction

  // Single bit (lane*8 + bitn) picked out of a word.
  function automatic logic bb_get_bit(input logic [31:0] w,
                                      input logic [1:0]  lane,
                                      input logic [2:0]  bitn);
    return w[{lane, bitn}];
  endfunction

endpackage

// File: rtl/bb_alias_decode.sv
module bb_alias_decode #(
  parameter logic [31:0] ALIAS_BASE  = 32'h2200_0000,
  parameter logic [31:0] REGION_BASE = 32'h2000_0000,
  parameter int          OFF_W       = 20
) (
  input  logic [31:0] addr_i,
  output logic        hit_o,
  output logic [31:0] word_addr_o,
  output logic [1:0]  lane_o,
  output logic [2:0]  bitn_o
);
  import bb_pkg::*;

  localparam int WIN_LSB = OFF_W + 5;
  localparam int PAD_W   = 32 - OFF_W;

  logic [31:0] byte_addr;

  always_comb begin
    hit_o       = (addr_i[31:WIN_LSB] == ALIAS_BASE[31:WIN_LSB]);
    byte_addr   = bb_region_byte(REGION_BASE, {{PAD_W{1'b0}}, addr_i[WIN_LSB-1:5]});
    word_addr_o = {byte_addr[31:2], 2'b00};
    lane_o      = byte_addr[1:0];
    bitn_o      = addr_i[4:2];
  end

endmodule

// File: rtl/bb_rmw_ctrl.sv
module bb_rmw_ctrl #(
  parameter int LANES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [31:0]       word_addr_i,
  input  logic [1:0]        lane_i,
  input  logic [2:0]        bitn_i,
  input  logic              val_i,
  input  logic [31:0]       mem_rdata_i,
  output logic              busy_o,
  output logic [31:0]       wb_addr_o,
  output logic [LANES-1:0]  wb_be_o,
  output logic [31:0]       wb_data_o
);
  import bb_pkg::*;

  bb_state_e   state_q;
  logic [31:0] addr_q;
  logic [1:0]  lane_q;
  logic [2:0]  bitn_q;
  logic        val_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= BB_IDLE;
      addr_q  <= '0;
      lane_q  <= '0;
      bitn_q  <= '0;
      val_q   <= 1'b0;
    end else begin
      case (state_q)
        BB_IDLE: if (start_i) begin
          state_q <= BB_WB;
          addr_q  <= word_addr_i;
          lane_q  <= lane_i;
          bitn_q  <= bitn_i;
          val_q   <= val_i;
        end
        default: state_q <= BB_IDLE;
      endcase
    end
  end

  for (genvar i = 0; i < LANES; i++) begin : g_be
    assign wb_be_o[i] = (lane_q == i[1:0]);
  end

  assign busy_o    = (state_q == BB_WB);
  assign wb_addr_o = addr_q;
  assign wb_data_o = bb_set_bit(mem_rdata_i, lane_q, bitn_q, val_q);

endmodule

// File: rtl/bb_rd_track.sv
module bb_rd_track (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        accept_i,
  input  logic        alias_i,
  input  logic [1:0]  lane_i,
  input  logic [2:0]  bitn_i,
  input  logic [31:0] mem_rdata_i,
  output logic        rvalid_o,
  output logic [31:0] rdata_o
);
  import bb_pkg::*;

  logic       alias_q;
  logic [1:0] lane_q;
  logic [2:0] bitn_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rvalid_o <= 1'b0;
      alias_q  <= 1'b0;
      lane_q   <= '0;
      bitn_q   <= '0;
    end else begin
      rvalid_o <= accept_i;
      if (accept_i) begin
        alias_q <= alias_i;
        lane_q  <= lane_i;
        bitn_q  <= bitn_i;
      end
    end
  end

  assign rdata_o = alias_q ? {31'd0, bb_get_bit(mem_rdata_i, lane_q, bitn_q)}
                           : mem_rdata_i;

endmodule

// File: rtl/bitband_bridge.sv
module bitband_bridge #(
  parameter logic [31:0] ALIAS_BASE  = 32'h2200_0000,
  parameter logic [31:0] REGION_BASE = 32'h2000_0000,
  parameter int          OFF_W       = 20
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        m_req,
  input  logic        m_we,
  input  logic [31:0] m_addr,
  input  logic [31:0] m_wdata,
  input  logic [3:0]  m_be,
  output logic        m_ready,
  output logic        m_rvalid,
  output logic [31:0] m_rdata,
  output logic        mem_req,
  output logic        mem_we,
  output logic [31:0] mem_addr,
  output logic [3:0]  mem_be,
  output logic [31:0] mem_wdata,
  input  logic [31:0] mem_rdata
);
  localparam int LANES = 4;

  // Named internal events, also observed by the checker.
  logic        hit;
  logic        busy;
  logic        rmw_start;
  logic        rd_accept;
  logic [31:0] word_addr;
  logic [1:0]  lane;
  logic [2:0]  bitn;
  logic [LANES-1:0] lane_oh;
  logic [31:0] wb_addr;
  logic [LANES-1:0] wb_be;
  logic [31:0] wb_data;

  bb_alias_decode #(
    .ALIAS_BASE (ALIAS_BASE),
    .REGION_BASE(REGION_BASE),
    .OFF_W      (OFF_W)
  ) u_dec (
    .addr_i     (m_addr),
    .hit_o      (hit),
    .word_addr_o(word_addr),
    .lane_o     (lane),
    .bitn_o     (bitn)
  );

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign lane_oh[i] = (lane == i[1:0]);
  end

  assign rmw_start = !busy && m_req && m_we && hit;
  assign rd_accept = !busy && m_req && !m_we;

  bb_rmw_ctrl #(.LANES(LANES)) u_rmw (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (rmw_start),
    .word_addr_i(word_addr),
    .lane_i     (lane),
    .bitn_i     (bitn),
    .val_i      (m_wdata[0]),
    .mem_rdata_i(mem_rdata),
    .busy_o     (busy),
    .wb_addr_o  (wb_addr),
    .wb_be_o    (wb_be),
    .wb_data_o  (wb_data)
  );

  bb_rd_track u_rd (
    .clk        (clk),
    .rst_n      (rst_n),
    .accept_i   (rd_accept),
    .alias_i    (hit),
    .lane_i     (lane),
    .bitn_i     (bitn),
    .mem_rdata_i(mem_rdata),
    .rvalid_o   (m_rvalid),
    .rdata_o    (m_rdata)
  );

  always_comb begin
    m_ready = busy || !rmw_start;
    if (busy) begin
      mem_req   = 1'b1;
      mem_we    = 1'b1;
      mem_addr  = wb_addr;
      mem_be    = wb_be;
      mem_wdata = wb_data;
    end else if (hit) begin
      mem_req   = m_req;
      mem_we    = 1'b0;
      mem_addr  = word_addr;
      mem_be    = lane_oh;
      mem_wdata = m_wdata;
    end else begin
      mem_req   = m_req;
      mem_we    = m_we;
      mem_addr  = m_addr;
      mem_be    = m_be;
      mem_wdata = m_wdata;
    end
  end

endmodule

// File: rtl/bb_checker.sv
module bb_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        m_req,
  input logic        m_we,
  input logic [31:0] m_addr,
  input logic        m_ready,
  input logic        m_rvalid,
  input logic [31:0] m_rdata,
  input logic        mem_we,
  input logic [31:0] mem_addr,
  input logic [3:0]  mem_be,
  input logic        hit,
  input logic        busy,
  input logic        rmw_start
);

  // R4: the read phase is followed at once by a write-back
  p_wb_follows_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rmw_start |=> (busy && mem_we));

  // R4: the write-back touches exactly one byte lane
  p_one_lane_r4: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> ($countones(mem_be) == 1));

  // R8: the master is held off during the read phase
  p_hold_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rmw_start |-> !m_ready);

  // R6: an accepted alias read returns only bit 0
  p_alias_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (m_req && m_ready && !m_we && hit && !busy) |=> (m_rvalid && (m_rdata[31:1] == 31'd0)));

  // R7: outside the window the address passes unchanged
  p_pass_addr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (m_req && !hit && !busy) |-> (mem_addr == m_addr));

  // R7: valid strobe only after an accepted read
  p_rvalid_src_r7: assert property (@(posedge clk) disable iff (!rst_n)
    m_rvalid |-> $past(m_req && m_ready && !m_we));

endmodule

bind bitband_bridge bb_checker u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .m_req    (m_req),
  .m_we     (m_we),
  .m_addr   (m_addr),
  .m_ready  (m_ready),
  .m_rvalid (m_rvalid),
  .m_rdata  (m_rdata),
  .mem_we   (mem_we),
  .mem_addr (mem_addr),
  .mem_be   (mem_be),
  .hit      (hit),
  .busy     (busy),
  .rmw_start(rmw_start)
);

// File: tb/tb_bitband_bridge.sv
module tb_bitband_bridge;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        m_req = 1'b0, m_we = 1'b0;
  logic [31:0] m_addr = '0, m_wdata = '0;
  logic [3:0]  m_be = '0;
  logic        m_ready, m_rvalid;
  logic [31:0] m_rdata;
  logic        mem_req, mem_we;
  logic [31:0] mem_addr, mem_wdata;
  logic [3:0]  mem_be;
  logic [31:0] mem_rdata;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  bitband_bridge dut (.*);

  // Backing memory: 256 words, one-cycle read latency.
  logic [31:0] ram [256];
  logic [31:0] rdq = '0;
  assign mem_rdata = rdq;
  always @(posedge clk) begin
    if (mem_req) begin
      rdq <= ram[mem_addr[9:2]];
      if (mem_we)
        for (int b = 0; b < 4; b++)
          if (mem_be[b]) ram[mem_addr[9:2]][8*b +: 8] <= mem_wdata[8*b +: 8];
    end
  end

  // Expected contents, one byte per entry.
  logic [7:0] shadow [1024];

  function automatic bit in_win(input logic [31:0] a);
    return (a >= 32'h2200_0000) && (a < 32'h2400_0000);
  endfunction
  function automatic logic [31:0] exp_byte(input logic [31:0] a);
    return 32'h2000_0000 + ((a - 32'h2200_0000) >> 5);
  endfunction
  function automatic int exp_bit(input logic [31:0] a);
    return int'((a >> 2) & 32'd7);
  endfunction
  function automatic logic [31:0] shadow_word(input logic [31:0] a);
    int i;
    i = int'(a[9:0]) & ~3;
    return {shadow[i+3], shadow[i+2], shadow[i+1], shadow[i]};
  endfunction

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", rq, act, exp);
    end
  endtask

  // First- and last-cycle memory port samples of the latest access.
  logic        f_req, f_we, l_we;
  logic [31:0] f_addr, f_wdata, l_addr, l_wdata;
  logic [3:0]  f_be, l_be;

  task automatic access(input logic we, input logic [31:0] addr, input logic [31:0] wd,
                        input logic [3:0] be, output logic [31:0] rd,
                        output logic rv, output int ncyc);
    @(negedge clk);
    m_req = 1'b1; m_we = we; m_addr = addr; m_wdata = wd; m_be = be;
    ncyc = 0;
    forever begin
      #1;
      ncyc++;
      if (ncyc == 1) begin
        f_req = mem_req; f_we = mem_we; f_addr = mem_addr; f_be = mem_be; f_wdata = mem_wdata;
      end
      l_we = mem_we; l_addr = mem_addr; l_be = mem_be; l_wdata = mem_wdata;
      if (m_ready || ncyc > 8) break;
      @(negedge clk);
    end
    @(posedge clk);
    @(negedge clk);
    rd = m_rdata; rv = m_rvalid;
    m_req = 1'b0; m_we = 1'b0;
  endtask

  task automatic alias_write(input logic [31:0] a, input logic [31:0] wd);
    logic [31:0] rd, bw;
    logic rv;
    int n, li, bi;
    bw = exp_byte(a);
    li = int'(bw[1:0]);
    bi = exp_bit(a);
    access(1'b1, a, wd, 4'hF, rd, rv, n);
    chk("R4 alias write cycles", n, 2);
    chk("R8 read phase is a read", {31'd0, f_we}, 0);
    chk("R3 read phase word address", f_addr, {bw[31:2], 2'b00});
    chk("R4 write-back enables one lane", {28'd0, l_be}, 32'd1 << li);
    chk("R4 write-back address", l_addr, {bw[31:2], 2'b00});
    shadow[int'(bw[9:0])][bi] = wd[0];
    chk("R5 write-back lane byte", {24'd0, l_wdata[8*li +: 8]}, {24'd0, shadow[int'(bw[9:0])]});
  endtask

  task automatic alias_read(input logic [31:0] a);
    logic [31:0] rd, bw;
    logic rv;
    int n;
    bw = exp_byte(a);
    access(1'b0, a, 32'hDEAD_BEEF, 4'hF, rd, rv, n);
    chk("R6 alias read cycles", n, 1);
    chk("R3 alias read lane enable", {28'd0, f_be}, 32'd1 << bw[1:0]);
    chk("R6 alias read valid", {31'd0, rv}, 1);
    chk("R6 alias read data", rd, {31'd0, shadow[int'(bw[9:0])][exp_bit(a)]});
  endtask

  task automatic pass_write(input logic [31:0] a, input logic [31:0] wd, input logic [3:0] be);
    logic [31:0] rd;
    logic rv;
    int n;
    access(1'b1, a, wd, be, rd, rv, n);
    chk("R7 pass write cycles", n, 1);
    chk("R7 pass write address", f_addr, a);
    chk("R7 pass write data/enables", {f_wdata[27:0], f_be}, {wd[27:0], be});
    chk("R2 pass write is a write", {31'd0, f_we}, 1);
    for (int b = 0; b < 4; b++)
      if (be[b]) shadow[(int'(a[9:0]) & ~3) + b] = wd[8*b +: 8];
  endtask

  task automatic pass_read(input logic [31:0] a);
    logic [31:0] rd;
    logic rv;
    int n;
    access(1'b0, a, 32'h0, 4'hF, rd, rv, n);
    chk("R7 pass read address", f_addr, a);
    chk("R7 pass read valid", {31'd0, rv}, 1);
    chk("R7 pass read data", rd, shadow_word(a));
  endtask

  function automatic logic [31:0] rand_alias();
    logic [31:0] off;
    off = $urandom % 1024;
    return 32'h2200_0000 + (off << 5) + (($urandom % 8) << 2);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd5150));
    for (int i = 0; i < 256; i++) ram[i] = '0;
    for (int i = 0; i < 1024; i++) shadow[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset ready", {31'd0, m_ready}, 1);
    chk("R1 reset rvalid", {31'd0, m_rvalid}, 0);
    chk("R9 idle mem_req", {31'd0, mem_req}, 0);

    // Worked mapping example (R3), bit 2 of byte 0x300.
    alias_write(32'h2200_6008, 32'h1);
    chk("R3 worked example byte address", f_addr, 32'h2000_0300);
    pass_read(32'h2000_0300);
    chk("R3 worked example bit", rd_bit(32'h2000_0300), 32'h4);
    alias_read(32'h2200_6008);

    // R5: upper write-data bits ignored.
    pass_write(32'h2000_0040, 32'hFFFF_FFFF, 4'hF);
    alias_write(32'h2200_0000 + (32'h43 << 5) + (7 << 2), 32'hFFFF_FFFE);
    pass_read(32'h2000_0040);
    alias_write(32'h2200_0000 + (32'h41 << 5) + (0 << 2), 32'h0000_0000);
    alias_write(32'h2200_0000 + (32'h41 << 5) + (0 << 2), 32'h8000_0001);
    pass_read(32'h2000_0040);

    // R2 window edges.
    pass_write(32'h21FF_FFFC, 32'hA5A5_1234, 4'b0101);
    pass_read(32'h21FF_FFFC);
    pass_write(32'h2400_0000, 32'h0BAD_F00D, 4'b1010);
    pass_read(32'h2400_0000);
    alias_write(32'h23FF_FFFC, 32'h1);
    alias_read(32'h23FF_FFFC);
    alias_write(32'h2200_0000, 32'h1);
    alias_read(32'h2200_0000);

    for (int k = 0; k < 400; k++) begin
      logic [31:0] a;
      a = {22'h080000, 8'($urandom), 2'b00};
      case ($urandom % 4)
        0: alias_write(rand_alias(), $urandom);
        1: alias_read(rand_alias());
        2: pass_write(a, $urandom, 4'($urandom));
        default: pass_read(a);
      endcase
    end

    @(negedge clk);
    chk("R9 mem_req after traffic", {31'd0, mem_req}, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  function automatic logic [31:0] rd_bit(input logic [31:0] a);
    return {24'd0, shadow[int'(a[9:0])]} & 32'h4;
  endfunction

endmodule